// File: doc/BRIEF.md
# Intruder Alarm Control State Machine

This block is the control core of a simple intruder alarm. It watches two inputs: an active-low system switch (`sys_on_n`, 0 means the system is switched on) and a break-in sensor (`breach`, 1 means an intrusion is sensed). It drives two indicators: an armed lamp and an alarm driver. The state is held in a two-bit register that updates on the rising clock edge. Next-state sequencing and output decoding are combinational logic kept apart from that register.

There are three states:
- UNARMED (code 00): the system is switched off.
- ARMED (code 01): the system is on and watching the sensor.
- SOUNDING (code 10): an intrusion has been seen.

The transitions are:
- ARM goes from UNARMED to ARMED when the switch is on.
- TRIP goes from ARMED to SOUNDING when the switch is on and a break-in is sensed.
- DISARM goes from ARMED back to UNARMED when the switch is off.
- SILENCE goes from SOUNDING back to UNARMED when the switch is off.
- HOLD keeps each state otherwise.

Once in SOUNDING, the alarm latches and ignores the sensor. Only turning the switch off ends it. The unused code 11 falls back to UNARMED on the next edge.

A synchronous active-high clear (`clr`) forces UNARMED on the next rising edge. It overrides every input-driven transition. Outputs depend only on the registered state (Moore), so they never react to an input change until the next edge.

Top module: `intrusion_alarm_ctrl`

## Requirements
- R1: When `clr`=1 at a rising edge, the machine enters UNARMED and both outputs are 0 after that edge, whatever `sys_on_n` and `breach` are.
- R2: The outputs decode the state as follows: UNARMED gives `armed_o`=0 and `alarm_o`=0; ARMED gives `armed_o`=1 and `alarm_o`=0; SOUNDING gives `armed_o`=0 and `alarm_o`=1. The two outputs are never 1 together.
- R3: In UNARMED, `sys_on_n`=0 at an edge moves to ARMED (ARM). `sys_on_n`=1 keeps UNARMED. `breach` has no effect in this state.
- R4: In ARMED, `sys_on_n`=1 at an edge moves to UNARMED (DISARM), whatever `breach` is.
- R5: In ARMED with `sys_on_n`=0, `breach`=1 at an edge moves to SOUNDING (TRIP), and `breach`=0 keeps ARMED.
- R6: In SOUNDING with `sys_on_n`=0, the machine stays in SOUNDING whatever `breach` is, including after the sensor returns to 0.
- R7: In SOUNDING, `sys_on_n`=1 at an edge moves to UNARMED (SILENCE).
- R8: Input changes between clock edges do not change the outputs; the outputs change only after a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear to UNARMED |
| sys_on_n | input | 1 | System switch, active low (0 = on) |
| breach | input | 1 | Break-in sensor, 1 = intrusion |
| armed_o | output | 1 | Armed indicator |
| alarm_o | output | 1 | Alarm driver |

## Verification
The hardest behaviour to show from the ports is the latch in SOUNDING. The stimulus must first arm the machine, then trip it, and then drop and raise `breach` several times while the switch stays on, to show that the sensor no longer matters. After that it silences the alarm, re-arms without a breach, and asserts `clr` while sounding, to separate clear priority from the normal SILENCE path. Inputs are changed half a cycle before each edge so that R8 is checked in the gap as well.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_UNARMED  = 2'b00,
        ST_ARMED    = 2'b01,
        ST_SOUNDING = 2'b10
    } alarm_state_t;

    typedef struct packed {
        logic armed;
        logic alarm;
    } alarm_out_t;
endpackage

// File: rtl/alarm_next_state.sv
module alarm_next_state
    import alarm_pkg::*;
(
    input  alarm_state_t cur_state,
    input  logic         sys_on_n,
    input  logic         breach,
    output alarm_state_t nxt_state
);
    always_comb begin
        nxt_state = ST_UNARMED;
        unique case (cur_state)
            ST_UNARMED:  nxt_state = sys_on_n ? ST_UNARMED : ST_ARMED;
            ST_ARMED: begin
                if (sys_on_n)    nxt_state = ST_UNARMED;
                else if (breach) nxt_state = ST_SOUNDING;
                else             nxt_state = ST_ARMED;
            end
            ST_SOUNDING: nxt_state = sys_on_n ? ST_UNARMED : ST_SOUNDING;
            default:     nxt_state = ST_UNARMED;
        endcase
    end
endmodule

// File: rtl/alarm_state_reg.sv
module alarm_state_reg
    import alarm_pkg::*;
(
    input  logic         clk,
    input  logic         clr,
    input  alarm_state_t nxt_state,
    output alarm_state_t cur_state
);
    always_ff @(posedge clk) begin
        if (clr) cur_state <= ST_UNARMED;
        else     cur_state <= nxt_state;
    end

    // R1: the first edge after clear is released must show the cleared state
    a_r1_clear_wins: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> cur_state == ST_UNARMED);
endmodule

// File: rtl/alarm_out_decode.sv
module alarm_out_decode
    import alarm_pkg::*;
(
    input  alarm_state_t cur_state,
    output alarm_out_t   outs
);
    always_comb begin
        outs = '0;
        unique case (cur_state)
            ST_UNARMED:  outs = '{armed: 1'b0, alarm: 1'b0};
            ST_ARMED:    outs = '{armed: 1'b1, alarm: 1'b0};
            ST_SOUNDING: outs = '{armed: 1'b0, alarm: 1'b1};
            default:     outs = '0;
        endcase
    end
endmodule

// File: rtl/intrusion_alarm_ctrl.sv
module intrusion_alarm_ctrl
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic sys_on_n,
    input  logic breach,
    output logic armed_o,
    output logic alarm_o
);
    alarm_state_t cur_state;
    alarm_state_t nxt_state;
    alarm_out_t   outs;

    alarm_next_state u_next (
        .cur_state (cur_state),
        .sys_on_n  (sys_on_n),
        .breach    (breach),
        .nxt_state (nxt_state)
    );

    alarm_state_reg u_reg (
        .clk       (clk),
        .clr       (clr),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    alarm_out_decode u_dec (
        .cur_state (cur_state),
        .outs      (outs)
    );

    assign armed_o = outs.armed;
    assign alarm_o = outs.alarm;

    a_r2_never_both: assert property (@(posedge clk) disable iff (clr)
        !(armed_o && alarm_o));
    a_r3_arm: assert property (@(posedge clk) disable iff (clr)
        (cur_state == ST_UNARMED && !sys_on_n) |=> cur_state == ST_ARMED);
    a_r4_disarm: assert property (@(posedge clk) disable iff (clr)
        (cur_state == ST_ARMED && sys_on_n) |=> cur_state == ST_UNARMED);
    a_r5_trip: assert property (@(posedge clk) disable iff (clr)
        (cur_state == ST_ARMED && !sys_on_n && breach) |=> cur_state == ST_SOUNDING);
    a_r6_latched: assert property (@(posedge clk) disable iff (clr)
        (cur_state == ST_SOUNDING && !sys_on_n) |=> alarm_o);
    a_r7_silence: assert property (@(posedge clk) disable iff (clr)
        (cur_state == ST_SOUNDING && sys_on_n) |=> (!alarm_o && !armed_o));
endmodule

// File: tb/tb_intrusion_alarm_ctrl.sv
module tb_intrusion_alarm_ctrl;
    logic clk = 1'b0;
    logic clr = 1'b1;
    logic sys_on_n = 1'b1;
    logic breach = 1'b0;
    logic armed_o, alarm_o;

    int errors = 0;
    int checks = 0;
    int model = 0;   // 0 unarmed, 1 armed, 2 sounding
    bit done = 1'b0;

    intrusion_alarm_ctrl dut (
        .clk(clk), .clr(clr), .sys_on_n(sys_on_n), .breach(breach),
        .armed_o(armed_o), .alarm_o(alarm_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag);
        logic ea, el;
        ea = (model == 1);
        el = (model == 2);
        checks++;
        if (armed_o !== ea || alarm_o !== el) begin
            errors++;
            $display("FAIL %s: armed/alarm = %b%b expected %b%b at %0t",
                     tag, armed_o, alarm_o, ea, el, $time);
        end
    endtask

    task automatic step(input logic c, input logic on_n, input logic b,
                        input string tag);
        @(negedge clk);
        clr = c; sys_on_n = on_n; breach = b;
        #1 check("R8");
        @(posedge clk);
        if (c) model = 0;
        else case (model)
            0: model = on_n ? 0 : 1;
            1: model = on_n ? 0 : (b ? 2 : 1);
            2: model = on_n ? 0 : 2;
            default: model = 0;
        endcase
        #1 check(tag);
    endtask

    initial begin
        step(1, 0, 1, "R1");          // clear wins over ARM
        step(0, 1, 1, "R3");          // off + breach stays unarmed
        step(0, 1, 0, "R3");
        step(0, 0, 1, "R3");          // ARM, breach ignored
        step(0, 0, 0, "R5");          // hold armed
        step(0, 1, 1, "R4");          // DISARM with breach
        step(0, 0, 0, "R3");
        step(0, 1, 0, "R4");
        step(0, 0, 0, "R3");
        step(0, 0, 1, "R5");          // TRIP
        step(0, 0, 0, "R6");          // latched, sensor clear
        step(0, 0, 1, "R6");
        step(0, 0, 0, "R6");
        step(0, 0, 0, "R2");
        step(0, 1, 0, "R7");          // SILENCE
        step(0, 0, 0, "R3");
        step(0, 0, 1, "R5");
        step(1, 0, 1, "R1");          // clear while sounding
        step(0, 1, 0, "R1");
        step(0, 0, 0, "R3");
        step(1, 0, 0, "R1");          // clear while armed
        step(0, 0, 0, "R3");
        step(0, 0, 1, "R5");
        step(0, 1, 1, "R7");          // silence with breach held
        step(0, 1, 0, "R2");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule